// File: doc/BRIEF.md
# Character Display Instruction Executor

This block runs the instructions of a single-line character display controller. A host writes 16-bit instruction words on a strobe. The block decodes them and keeps three kinds of state: the address counter for the display RAM, the entry-mode flags, and the whole-display shift offset. It also holds the 12-entry display RAM. Data bytes arrive on a second strobe and are tagged with a target memory: the display RAM, the custom-glyph RAM or the mark RAM. After each accepted byte the block steps the address counter. When shifting is enabled, display-RAM writes also move the shift offset.

The glyph and mark memories live outside this block. For those targets the block only does the address stepping. A display scanner reads the display RAM through a registered read port and adds the exported shift offset to its column index. Clearing the display writes the space code into the RAM one entry per clock. A busy output covers that whole span.

Top module: `cdisp_exec`

## Requirements
- R1: After synchronous reset the address counter and shift offset are 0, the step direction is increment (`inc_mode`=1), shifting is disabled (`shift_en`=0) and `busy` is 0.
- R2: The opcode is taken from bits 10:8 of the instruction word, and bits 15:11 are ignored. If bit 10 is set the word is Entry Mode Set. Otherwise, if bit 9 is set, it is Return Home. Otherwise, if bit 8 is set, it is Clear Display. Clear Display raises `busy` for exactly 12 cycles, starting the cycle after the strobe.
- R3: Clear Display writes 0x20 into all 12 display RAM entries. It sets the address counter to 0 and `inc_mode` to 1, and leaves `shift_en` and the shift offset unchanged.
- R4: Entry Mode Set copies instruction bit 1 to `inc_mode` (1 = increment) and bit 0 to `shift_en`. It changes neither the address counter nor the RAM.
- R5: An accepted data write with target 0 (display) stores the byte at the current address. The address counter then steps +1 when `inc_mode`=1 and -1 otherwise, wrapping modulo 12 in both directions.
- R6: When `shift_en`=1, each accepted display write moves the shift offset +1 (left) if `inc_mode`=1 and -1 (right) if `inc_mode`=0. The offset wraps modulo 12.
- R7: Data writes with target 1 (glyph) or 2 or 3 (mark) step the address counter the same way. They never change the shift offset and never write the display RAM.
- R8: Return Home sets the address counter and the shift offset to 0. It leaves the RAM contents and both entry flags unchanged.
- R9: A word with bits 10:8 all zero is a reserved test code and changes no state.
- R10: While `busy` is 1, instruction strobes and data strobes are dropped.
- R11: If the instruction strobe and the data strobe arrive in the same cycle, the instruction is executed and the data write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Instruction write strobe |
| cmd_word | input | 16 | Instruction word |
| dat_we | input | 1 | Data write strobe |
| dat_target | input | 2 | Data target: 0 display, 1 glyph, 2/3 mark |
| dat_byte | input | 8 | Data byte |
| rd_addr | input | 4 | Display RAM read address for the scanner |
| rd_data | output | 8 | Registered display RAM read data |
| busy | output | 1 | Clear in progress |
| addr_ctr | output | 4 | Address counter |
| inc_mode | output | 1 | Step direction, 1 = increment |
| shift_en | output | 1 | Whole-display shift enabled |
| shift_ofs | output | 4 | Display shift offset |

## Verification
Data writes are tried in four patterns: increment without shift, decrement across the zero boundary, increment across the top boundary, and both directions with shift enabled. These separate a fault in the step direction, a fault in the modulo wrap, and a fault in the offset coupling. Glyph and mark writes with shifting on tell a correct target check apart from one that shifts on every write. Strobes sent during a clear, a cleared RAM filled with non-space bytes beforehand, and two differently padded test codes show whether the gating and the don't-care decode hold.

// File: rtl/cdisp_pkg.sv
package cdisp_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_HOME  = 2'd2,
    OP_ENTRY = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    TGT_DISP  = 2'd0,
    TGT_GLYPH = 2'd1,
    TGT_MARK  = 2'd2,
    TGT_MARK2 = 2'd3
  } tgt_e;
endpackage

// File: rtl/cdisp_decode.sv
module cdisp_decode
  import cdisp_pkg::*;
#(
  parameter int CW      = 16,
  parameter int OPC_LSB = 8
) (
  input  logic [CW-1:0] word,
  output op_e           op,
  output logic          ent_inc,
  output logic          ent_shift
);
  logic [2:0] opc;
  assign opc       = word[OPC_LSB +: 3];
  assign ent_inc   = word[1];
  assign ent_shift = word[0];

  always_comb begin
    if (opc[2])      op = OP_ENTRY;
    else if (opc[1]) op = OP_HOME;
    else if (opc[0]) op = OP_CLEAR;
    else             op = OP_NONE;
  end
endmodule

// File: rtl/cdisp_modstep.sv
module cdisp_modstep #(
  parameter int N  = 12,
  localparam int W = $clog2(N)
) (
  input  logic [W-1:0] cur,
  input  logic         up,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] TOP = W'(N - 1);

  always_comb begin
    if (up) nxt = (cur == TOP) ? '0 : cur + 1'b1;
    else    nxt = (cur == '0) ? TOP : cur - 1'b1;
  end
endmodule

// File: rtl/cdisp_ram.sv
module cdisp_ram #(
  parameter int DEPTH = 12,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cdisp_exec.sv
module cdisp_exec
  import cdisp_pkg::*;
#(
  parameter int            DEPTH   = 12,
  parameter int            DW      = 8,
  parameter int            CW      = 16,
  parameter int            OPC_LSB = 8,
  parameter logic [DW-1:0] SPACE   = 8'h20,
  localparam int           AW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_we,
  input  logic [CW-1:0] cmd_word,
  input  logic          dat_we,
  input  logic [1:0]    dat_target,
  input  logic [DW-1:0] dat_byte,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic [AW-1:0] addr_ctr,
  output logic          inc_mode,
  output logic          shift_en,
  output logic [AW-1:0] shift_ofs
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  op_e           op;
  logic          ent_inc, ent_shift;
  logic [AW-1:0] addr_q, ofs_q, clr_idx, addr_nxt, ofs_nxt;
  logic          inc_q, shift_q, busy_q;
  logic          cmd_ok, dat_ok, to_disp;
  logic          ram_we;
  logic [AW-1:0] ram_waddr;
  logic [DW-1:0] ram_wdata;

  cdisp_decode #(.CW(CW), .OPC_LSB(OPC_LSB)) u_dec (
    .word(cmd_word), .op(op), .ent_inc(ent_inc), .ent_shift(ent_shift)
  );

  cdisp_modstep #(.N(DEPTH)) u_addr_step (.cur(addr_q), .up(inc_q), .nxt(addr_nxt));
  cdisp_modstep #(.N(DEPTH)) u_ofs_step  (.cur(ofs_q),  .up(inc_q), .nxt(ofs_nxt));

  assign cmd_ok  = cmd_we && !busy_q;
  assign dat_ok  = dat_we && !busy_q && !cmd_we;
  assign to_disp = (tgt_e'(dat_target) == TGT_DISP);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      ofs_q   <= '0;
      inc_q   <= 1'b1;
      shift_q <= 1'b0;
      busy_q  <= 1'b0;
      clr_idx <= '0;
    end else if (busy_q) begin
      clr_idx <= clr_idx + 1'b1;
      if (clr_idx == LAST) busy_q <= 1'b0;
    end else if (cmd_ok) begin
      case (op)
        OP_CLEAR: begin
          addr_q  <= '0;
          inc_q   <= 1'b1;
          busy_q  <= 1'b1;
          clr_idx <= '0;
        end
        OP_HOME: begin
          addr_q <= '0;
          ofs_q  <= '0;
        end
        OP_ENTRY: begin
          inc_q   <= ent_inc;
          shift_q <= ent_shift;
        end
        default: ;
      endcase
    end else if (dat_ok) begin
      addr_q <= addr_nxt;
      if (to_disp && shift_q) ofs_q <= ofs_nxt;
    end
  end

  assign ram_we    = busy_q || (dat_ok && to_disp);
  assign ram_waddr = busy_q ? clr_idx : addr_q;
  assign ram_wdata = busy_q ? SPACE : dat_byte;

  cdisp_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assign busy      = busy_q;
  assign addr_ctr  = addr_q;
  assign inc_mode  = inc_q;
  assign shift_en  = shift_q;
  assign shift_ofs = ofs_q;

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    (addr_q <= LAST) && (ofs_q <= LAST)); // R5
  AST_CLEAR_START: assert property (@(posedge clk) disable iff (rst)
    (cmd_ok && op == OP_CLEAR) |=> busy_q && addr_q == '0 && inc_q && $stable(shift_q) && $stable(ofs_q)); // R3
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> $stable(addr_q) && $stable(inc_q) && $stable(shift_q) && $stable(ofs_q)); // R10
  AST_TEST_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cmd_ok && op == OP_NONE) |=> $stable(addr_q) && $stable(inc_q) && $stable(shift_q) && $stable(ofs_q) && !busy_q); // R9
  AST_NO_SHIFT_OTHER: assert property (@(posedge clk) disable iff (rst)
    (dat_we && !busy_q && !cmd_we && dat_target != 2'd0) |=> $stable(ofs_q)); // R7
  AST_HOME: assert property (@(posedge clk) disable iff (rst)
    (cmd_ok && op == OP_HOME) |=> addr_q == '0 && ofs_q == '0 && $stable(inc_q) && $stable(shift_q)); // R8
endmodule

// File: tb/test_cdisp_exec.sv
module test_cdisp_exec;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_we = 1'b0;
  logic [15:0] cmd_word = '0;
  logic       dat_we = 1'b0;
  logic [1:0] dat_target = '0;
  logic [7:0] dat_byte = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       busy, inc_mode, shift_en;
  logic [3:0] addr_ctr, shift_ofs;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  cdisp_exec i_cdisp_exec (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_word(cmd_word),
    .dat_we(dat_we), .dat_target(dat_target), .dat_byte(dat_byte),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .addr_ctr(addr_ctr),
    .inc_mode(inc_mode), .shift_en(shift_en), .shift_ofs(shift_ofs)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [15:0] w);
    @(negedge clk); cmd_we = 1'b1; cmd_word = w;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic send_dat(input logic [1:0] t, input logic [7:0] b);
    @(negedge clk); dat_we = 1'b1; dat_target = t; dat_byte = b;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); rd_addr = 4'(a);
    @(negedge clk); v = int'(rd_data);
  endtask

  task automatic wait_clear();
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 addr", addr_ctr, 0);
    chk("R1 ofs", shift_ofs, 0);
    chk("R1 inc", inc_mode, 1);
    chk("R1 shift", shift_en, 0);
    chk("R1 busy", busy, 0);
  endtask

  task automatic t_clear();
    int v;
    send_cmd(16'h0100);
    wait_clear();
    for (int i = 0; i < 12; i++) send_dat(2'd0, 8'(8'h41 + i));
    send_cmd(16'h0401);
    send_dat(2'd0, 8'h55);
    chk("R3 ofs before clear", shift_ofs, 11);
    send_cmd(16'hF900);
    chk("R2 busy first", busy, 1);
    repeat (11) @(negedge clk);
    chk("R2 busy last", busy, 1);
    @(negedge clk);
    chk("R2 busy end", busy, 0);
    chk("R3 addr", addr_ctr, 0);
    chk("R3 inc", inc_mode, 1);
    chk("R3 shift kept", shift_en, 1);
    chk("R3 ofs kept", shift_ofs, 11);
    for (int i = 0; i < 12; i++) begin
      rd(i, v);
      chk("R3 space", v, 32'h20);
    end
  endtask

  task automatic t_entry_inc();
    int v;
    send_cmd(16'h0100); wait_clear();
    send_cmd(16'h0402);
    chk("R4 inc", inc_mode, 1);
    chk("R4 shift", shift_en, 0);
    chk("R4 addr kept", addr_ctr, 0);
    send_dat(2'd0, 8'h41); send_dat(2'd0, 8'h42); send_dat(2'd0, 8'h43);
    chk("R5 addr inc", addr_ctr, 3);
    rd(0, v); chk("R5 ram0", v, 32'h41);
    rd(2, v); chk("R5 ram2", v, 32'h43);
    rd(3, v); chk("R5 ram3", v, 32'h20);
  endtask

  task automatic t_wrap();
    int v;
    send_cmd(16'h0200);
    send_cmd(16'h0400);
    chk("R4 dec", inc_mode, 0);
    send_dat(2'd0, 8'h5A);
    chk("R5 dec wrap", addr_ctr, 11);
    rd(0, v); chk("R5 ram at 0", v, 32'h5A);
    send_cmd(16'h0402);
    send_dat(2'd0, 8'h59);
    chk("R5 inc wrap", addr_ctr, 0);
    rd(11, v); chk("R5 ram at 11", v, 32'h59);
  endtask

  task automatic t_shift();
    send_cmd(16'h0200);
    send_cmd(16'h0403);
    send_dat(2'd0, 8'h31); send_dat(2'd0, 8'h32);
    chk("R6 left", shift_ofs, 2);
    send_cmd(16'h0401);
    send_dat(2'd0, 8'h33); send_dat(2'd0, 8'h34); send_dat(2'd0, 8'h35);
    chk("R6 right wrap", shift_ofs, 11);
    chk("R5 addr", addr_ctr, 11);
  endtask

  task automatic t_other_targets();
    int v;
    send_cmd(16'h0100); wait_clear();
    send_cmd(16'h0403);
    send_dat(2'd1, 8'h77);
    send_dat(2'd2, 8'h78);
    send_dat(2'd3, 8'h79);
    chk("R7 addr steps", addr_ctr, 3);
    chk("R7 ofs still", shift_ofs, 11);
    rd(0, v); chk("R7 ram0 untouched", v, 32'h20);
    rd(2, v); chk("R7 ram2 untouched", v, 32'h20);
  endtask

  task automatic t_home();
    int v;
    send_dat(2'd0, 8'h61);
    chk("R6 ofs moved", shift_ofs, 0);
    send_dat(2'd0, 8'h62);
    send_cmd(16'h0200);
    chk("R8 addr", addr_ctr, 0);
    chk("R8 ofs", shift_ofs, 0);
    chk("R8 inc kept", inc_mode, 1);
    chk("R8 shift kept", shift_en, 1);
    rd(3, v); chk("R8 ram kept", v, 32'h61);
  endtask

  task automatic t_test_code();
    send_cmd(16'h0401);
    send_dat(2'd0, 8'h10);
    send_cmd(16'h0000);
    send_cmd(16'hF8FF);
    chk("R9 busy", busy, 0);
    chk("R9 addr", addr_ctr, 11);
    chk("R9 ofs", shift_ofs, 11);
    chk("R9 inc", inc_mode, 0);
    chk("R9 shift", shift_en, 1);
  endtask

  task automatic t_busy_drop();
    int v;
    send_cmd(16'h0100);
    send_cmd(16'h0400);
    send_dat(2'd0, 8'h99);
    send_cmd(16'h0200);
    repeat (8) @(negedge clk);
    chk("R10 inc", inc_mode, 1);
    chk("R10 shift", shift_en, 1);
    chk("R10 addr", addr_ctr, 0);
    chk("R10 ofs", shift_ofs, 11);
    rd(0, v); chk("R10 ram0", v, 32'h20);
  endtask

  task automatic t_collide();
    int v;
    @(negedge clk);
    cmd_we = 1'b1; cmd_word = 16'h0402;
    dat_we = 1'b1; dat_target = 2'd0; dat_byte = 8'hAB;
    @(negedge clk);
    cmd_we = 1'b0; dat_we = 1'b0;
    chk("R11 entry done", shift_en, 0);
    chk("R11 addr kept", addr_ctr, 0);
    rd(0, v); chk("R11 ram kept", v, 32'h20);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_clear();
        t_entry_inc();
        t_wrap();
        t_shift();
        t_other_targets();
        t_home();
        t_test_code();
        t_busy_drop();
        t_collide();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule